// File: doc/BRIEF.md
# Log-Domain Approximate Divider

This block returns an approximate unsigned quotient of a 16-bit dividend `yIn` by a 16-bit divisor `xIn`. It never divides. It takes a base-2 logarithm of each operand, subtracts the divisor's logarithm from the dividend's, and raises two to the difference.

For the logarithm, the block locates the highest set bit of each operand, which gives the integer part. It then normalises the mantissa so that it sits between about 0.707 and 1.414, which leaves a small signed offset `d` from one. If the first mantissa is above the square-root-of-two threshold, the block halves it once more and raises the integer part by one. The fraction of the logarithm is a linear term `d/ln 2` plus a correction. A 16-entry table supplies the correction, indexed by the top four bits of `d`. The antilog reads two raised to the top six fractional bits of the difference from a 64-entry table, then shifts that value by the integer part of the difference.

The quotient comes out in unsigned fixed point with 8 fractional bits: 24 bits, of which 16 are integer bits. The pipeline has four stages (normalise, logarithm, subtract with antilog lookup, shift). It accepts one operand pair in every cycle, and each result appears a fixed four cycles after its operands. Because the error lives in the log domain, the relative error is about the same for small and large operands.

Top module: `logdiv_approx`

## Requirements
- R1: For an operand pair accepted with `validIn` high in cycle n, `validOut` is high in cycle n+4. The block accepts back-to-back pairs in consecutive cycles, and `validOut` is never high without a matching accepted pair.
- R2: While `rstN` is low, `validOut`, `quotOut` and `divZeroOut` are all 0.
- R3: For nonzero operands, `quotOut` (quotient times 256) differs from the exact value y*256/x by no more than one sixteenth of the exact value plus 2, for operands of any magnitude.
- R4: Equal nonzero operands give `quotOut` = 257. This is the antilog of a zero difference, taken at the centre of the first table interval.
- R5: `divZeroOut` is 1 exactly when the divisor was 0. In that case `quotOut` is all ones (0xFFFFFF), whatever the dividend.
- R6: A zero dividend with a nonzero divisor gives `quotOut` = 0 and `divZeroOut` = 0.
- R7: A result below the smallest fraction truncates to zero. A nonzero-divisor pair whose exact quotient is below 0.9/256 gives `quotOut` = 0.
- R8: While `validOut` is low, `quotOut` and `divZeroOut` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operand pair present this cycle |
| yIn | input | 16 | Dividend, unsigned |
| xIn | input | 16 | Divisor, unsigned |
| validOut | output | 1 | Result present this cycle |
| quotOut | output | 24 | Quotient, unsigned, 8 fractional bits |
| divZeroOut | output | 1 | Divisor was zero |

## Verification
The main function is tried four ways:
- Exact powers of two and equal operands. These separate the integer path (bit location and barrel shift) from the table paths.
- A sweep of dividends and divisors across every highest-bit position, sent back to back. It shows whether the relative error stays bounded at every magnitude and whether results keep their order at full rate.
- Pairs sent with irregular gaps. These tell a correct four-cycle latency from an off-by-one, and show whether the outputs hold between results.
- Zero operands and the extreme ratios (65535/1 and 1/65535). These exercise the saturation, forced-zero and truncation corners, which the tolerance check alone would not tell apart.

// File: rtl/logdiv_pkg.sv
package logdiv_pkg;

  // Stage load strobes issued by the control to the datapath.
  typedef struct packed {
    logic ldNorm;   // capture normalised operands
    logic ldLog;    // capture logarithms
    logic ldAnti;   // capture difference and antilog mantissa
    logic ldShift;  // capture shifted quotient
  } stageEn_t;

endpackage

// File: rtl/logdiv_ctrl.sv
module logdiv_ctrl
  import logdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     validIn,
  output stageEn_t en,
  output logic     validOut
);

  localparam int STAGES = 4;

  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[STAGES-2:0], validIn};
  end

  always_comb begin
    en.ldNorm  = validIn;
    en.ldLog   = vPipe[0];
    en.ldAnti  = vPipe[1];
    en.ldShift = vPipe[2];
  end

  assign validOut = vPipe[STAGES-1];

endmodule

// File: rtl/logdiv_logunit.sv
module logdiv_logunit
  import logdiv_pkg::*;
#(
  parameter int DW        = 16,
  parameter int LFW       = 10,
  parameter int LW        = 16,
  parameter int CORR_BITS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  stageEn_t      en,
  input  logic [DW-1:0] opIn,
  output logic          isZero,
  output logic [LW-1:0] logOut
);

  localparam int KW     = $clog2(DW) + 1;
  localparam int CORR_N = 1 << CORR_BITS;
  localparam int PW     = DW + LFW + 5;
  localparam logic [DW-1:0] THR = DW'($rtoi($sqrt(2.0) * (2.0 ** (DW - 1))));
  localparam int LINC   = $rtoi((2.0 ** (LFW + 2)) / $ln(2.0) + 0.5);

  // Correction table: log2(1+d) - d/ln2 at each interval centre, in units of 2^-LFW.
  logic [LW-1:0] corrRom [CORR_N];
  for (genvar j = 0; j < CORR_N; j++) begin : g_corr
    localparam real DM = -0.5 + (j + 0.5) / (1.0 * CORR_N);
    localparam real CV = ($ln(1.0 + DM) - DM) / $ln(2.0) * (2.0 ** LFW);
    assign corrRom[j] = LW'($rtoi(CV < 0.0 ? CV - 0.5 : CV + 0.5));
  end

  // Stage 1: normalise around sqrt(2).
  logic [KW-1:0]   msb, kNext, kR;
  logic [DW-1:0]   mant;
  logic signed [DW:0] dNext, dR;
  logic            zeroR;

  always_comb begin
    msb = '0;
    for (int i = 0; i < DW; i++)
      if (opIn[i]) msb = KW'(i);
    mant = DW'(opIn << (DW - 1 - int'(msb)));
    if (mant > THR) begin
      dNext = {1'b1, mant};                    // mant/2 - 1, scaled by 2^DW
      kNext = msb + KW'(1);
    end else begin
      dNext = {1'b0, mant[DW-2:0], 1'b0};      // mant - 1, scaled by 2^DW
      kNext = msb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kR <= '0; dR <= '0; zeroR <= 1'b0;
    end else if (en.ldNorm) begin
      kR <= kNext; dR <= dNext; zeroR <= (opIn == '0);
    end
  end

  // Stage 2: linear term plus interval correction.
  logic [CORR_BITS-1:0] idx;
  logic signed [PW-1:0] prod, lin;
  logic [LW-1:0]        logNext, logR;
  logic                 zero2R;

  always_comb begin
    idx     = {~dR[DW-1], dR[DW-2 -: CORR_BITS-1]};
    prod    = PW'(dR) * PW'(LINC);
    lin     = prod >>> (DW + 2);
    logNext = (LW'(kR) << LFW) + lin[LW-1:0] + corrRom[idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logR <= '0; zero2R <= 1'b0;
    end else if (en.ldLog) begin
      logR <= logNext; zero2R <= zeroR;
    end
  end

  assign logOut = logR;
  assign isZero = zero2R;

endmodule

// File: rtl/logdiv_datapath.sv
module logdiv_datapath
  import logdiv_pkg::*;
#(
  parameter int DW        = 16,
  parameter int OUT_FRAC  = 8,
  parameter int LFW       = 10,
  parameter int CORR_BITS = 4,
  parameter int ANTI_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stageEn_t               en,
  input  logic [DW-1:0]          yIn,
  input  logic [DW-1:0]          xIn,
  output logic [DW+OUT_FRAC-1:0] quotOut,
  output logic                   divZeroOut
);

  localparam int QW     = DW + OUT_FRAC;
  localparam int LW     = LFW + $clog2(DW) + 2;
  localparam int ZIW    = LW + 1 - LFW;
  localparam int AW     = DW;                  // antilog mantissa width, one integer bit
  localparam int ANTI_N = 1 << ANTI_BITS;
  localparam int WW     = QW + AW;
  localparam int SHOFF  = (AW - 1) - OUT_FRAC;

  // Operand 0 is the dividend, operand 1 the divisor.
  logic [DW-1:0] opArr   [2];
  logic [LW-1:0] logArr  [2];
  logic          zeroArr [2];

  assign opArr[0] = yIn;
  assign opArr[1] = xIn;

  for (genvar g = 0; g < 2; g++) begin : g_log
    logdiv_logunit #(.DW(DW), .LFW(LFW), .LW(LW), .CORR_BITS(CORR_BITS)) u_log (
      .clk(clk), .rstN(rstN), .en(en), .opIn(opArr[g]),
      .isZero(zeroArr[g]), .logOut(logArr[g])
    );
  end

  // Antilog table: 2^((i+0.5)/ANTI_N), one integer bit, AW-1 fraction bits.
  logic [AW-1:0] antiRom [ANTI_N];
  for (genvar i = 0; i < ANTI_N; i++) begin : g_anti
    assign antiRom[i] = AW'($rtoi((2.0 ** ((i + 0.5) / (1.0 * ANTI_N))) * (2.0 ** (AW - 1)) + 0.5));
  end

  // Stage 3: subtract logarithms, look up fractional antilog.
  logic [LW:0]    zDiff;
  logic [AW-1:0]  mantR;
  logic [ZIW-1:0] ziR;
  logic           dz3R, yz3R;

  assign zDiff = {logArr[0][LW-1], logArr[0]} - {logArr[1][LW-1], logArr[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mantR <= '0; ziR <= '0; dz3R <= 1'b0; yz3R <= 1'b0;
    end else if (en.ldAnti) begin
      mantR <= antiRom[zDiff[LFW-1 -: ANTI_BITS]];
      ziR   <= zDiff[LW:LFW];
      dz3R  <= zeroArr[1];
      yz3R  <= zeroArr[0];
    end
  end

  // Stage 4: barrel shift by the integer part, saturate or truncate.
  int            shAmt;
  logic [WW-1:0] wide;
  logic          sat;
  logic [QW-1:0] shifted, quotNext;

  always_comb begin
    shAmt   = int'($signed(ziR)) - SHOFF;
    wide    = '0;
    sat     = 1'b0;
    shifted = '0;
    if (shAmt >= 0) begin
      if (shAmt > QW) sat = 1'b1;
      else begin
        wide    = WW'(mantR) << shAmt;
        sat     = |wide[WW-1:QW];
        shifted = wide[QW-1:0];
      end
    end else if (-shAmt < AW) begin
      shifted = QW'(mantR >> (-shAmt));
    end
    if (dz3R)      quotNext = '1;
    else if (yz3R) quotNext = '0;
    else if (sat)  quotNext = '1;
    else           quotNext = shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotOut <= '0; divZeroOut <= 1'b0;
    end else if (en.ldShift) begin
      quotOut <= quotNext; divZeroOut <= dz3R;
    end
  end

endmodule

// File: rtl/logdiv_approx.sv
module logdiv_approx
  import logdiv_pkg::*;
#(
  parameter int DW        = 16,
  parameter int OUT_FRAC  = 8,
  parameter int LFW       = 10,
  parameter int CORR_BITS = 4,
  parameter int ANTI_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   validIn,
  input  logic [DW-1:0]          yIn,
  input  logic [DW-1:0]          xIn,
  output logic                   validOut,
  output logic [DW+OUT_FRAC-1:0] quotOut,
  output logic                   divZeroOut
);

  stageEn_t en;

  logdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .en(en), .validOut(validOut)
  );

  logdiv_datapath #(
    .DW(DW), .OUT_FRAC(OUT_FRAC), .LFW(LFW),
    .CORR_BITS(CORR_BITS), .ANTI_BITS(ANTI_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .en(en), .yIn(yIn), .xIn(xIn),
    .quotOut(quotOut), .divZeroOut(divZeroOut)
  );

endmodule

// File: rtl/logdiv_approx_chk.sv
module logdiv_approx_chk #(
  parameter int DW = 16,
  parameter int QW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          validIn,
  input logic [DW-1:0] yIn,
  input logic [DW-1:0] xIn,
  input logic          validOut,
  input logic [QW-1:0] quotOut,
  input logic          divZeroOut
);

  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst < 4)  sinceRst <= sinceRst + 3'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4) |-> (validOut == $past(validIn, 4))); // R1

  AST_DIVZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4 && validOut) |-> (divZeroOut == $past(xIn == '0, 4))); // R5

  AST_DIVZERO_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && divZeroOut) |-> (&quotOut)); // R5

  AST_ZERO_DIVIDEND: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4 && validOut && $past(yIn == '0 && xIn != '0, 4)) |-> (quotOut == '0)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!validOut) |-> ($stable(quotOut) && $stable(divZeroOut))); // R8

endmodule

bind logdiv_approx logdiv_approx_chk #(.DW(DW), .QW(DW + OUT_FRAC)) u_chk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .yIn(yIn), .xIn(xIn),
  .validOut(validOut), .quotOut(quotOut), .divZeroOut(divZeroOut)
);

// File: tb/sim_logdiv_approx.sv
module sim_logdiv_approx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [15:0] yIn = '0;
  logic [15:0] xIn = '0;
  logic        validOut;
  logic [23:0] quotOut;
  logic        divZeroOut;

  always #4 clk = ~clk;   // 125 MHz

  logdiv_approx u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .yIn(yIn), .xIn(xIn),
    .validOut(validOut), .quotOut(quotOut), .divZeroOut(divZeroOut)
  );

  typedef struct {
    int          due;
    logic [15:0] y;
    logic [15:0] x;
  } item_t;

  item_t       pend[$];
  int          cyc = 0;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;
  bit          haveLast = 1'b0;
  bit          expNow;
  logic [23:0] lastQ;
  logic        lastDz;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] y, logic [15:0] x);
    @(negedge clk);
    yIn = y; xIn = x; validIn = 1'b1;
    pend.push_back('{cyc + 4, y, x});
  endtask

  task automatic idle(int n);
    if (n > 0) begin
      @(negedge clk);
      validIn = 1'b0;
      repeat (n - 1) @(negedge clk);
    end
  endtask

  task automatic judge(item_t it);
    real e;
    real dev;
    if (it.x == 16'd0) begin
      chk(divZeroOut == 1'b1, "R5 flag on zero divisor", divZeroOut, 1);
      chk(quotOut == 24'hFFFFFF, "R5 saturated quotient", quotOut, 24'hFFFFFF);
    end else begin
      chk(divZeroOut == 1'b0, "R5 flag clear", divZeroOut, 0);
      e = real'(it.y) * 256.0 / real'(it.x);
      if (it.y == 16'd0)
        chk(quotOut == 24'd0, "R6 zero dividend", quotOut, 0);
      else if (it.y == it.x)
        chk(quotOut == 24'd257, "R4 equal operands", quotOut, 257);
      else if (e < 0.9)
        chk(quotOut == 24'd0, "R7 truncation to zero", quotOut, 0);
      else begin
        dev = real'(quotOut) - e;
        if (dev < 0.0) dev = -dev;
        chk(dev <= e / 16.0 + 2.0, "R3 bounded relative error", quotOut, longint'($rtoi(e)));
      end
    end
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (pend.size() > 0 && pend[0].due < cyc) begin
        chk(1'b0, "R1 result missing", 0, 1);
        void'(pend.pop_front());
      end
      expNow = (pend.size() > 0) && (pend[0].due == cyc);
      if (validOut || expNow)
        chk(validOut == expNow, "R1 valid timing", validOut, expNow);
      if (validOut && expNow) begin
        judge(pend.pop_front());
        lastQ = quotOut; lastDz = divZeroOut; haveLast = 1'b1;
      end else if (!validOut && haveLast) begin
        chk(quotOut == lastQ, "R8 quotient held", quotOut, lastQ);
        chk(divZeroOut == lastDz, "R8 flag held", divZeroOut, lastDz);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(validOut == 1'b0, "R2 reset valid", validOut, 0);
    chk(quotOut == 24'd0, "R2 reset quotient", quotOut, 0);
    chk(divZeroOut == 1'b0, "R2 reset flag", divZeroOut, 0);
    rstN = 1'b1;
    idle(2);

    // Directed corners.
    send(16'd1000, 16'd10);   idle(6);
    send(16'd0, 16'd5);       idle(1);
    send(16'd77, 16'd0);
    send(16'd0, 16'd0);
    send(16'd1234, 16'd1234);
    send(16'd1, 16'd65535);
    send(16'd3, 16'd65535);
    send(16'd65535, 16'd1);
    send(16'd65535, 16'd65535);
    send(16'd4096, 16'd8);
    send(16'd8, 16'd4096);
    idle(8);

    // Magnitude sweep, back to back.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        send(16'((1 << a) + ((a * 131 + b * 29) % (1 << a))),
             16'((1 << b) + ((a * 53 + b * 197) % (1 << b))));
      end
    end
    idle(3);

    // Irregular gaps.
    for (int i = 0; i < 24; i++) begin
      send(16'(i * 3001 + 13), 16'(i * 577 + 1));
      idle(i % 3);
    end
    idle(1);

    while (pend.size() > 0) @(negedge clk);
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", pend.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule